// File: doc/BRIEF.md
# Grouped-Direction General-Purpose I/O Port

This block gives a board controller thirteen general-purpose lines behind a small register port (address, write data, write strobe, combinational read data). Ten lines are bidirectional. Their direction is not chosen per pin. One control bit sets the direction for a whole group, and the groups hold five, three and two lines. Two more lines can only be read, and one line can only be driven.

Software writes a data register to set the output values and a direction register to turn groups into drivers. The data register reads back the live state of every line. A line that is driving returns its register value. A line that is an input returns its pin level after a two-flop synchronizer. The block supplies the per-line drive values and one tri-state enable per group. Pad cells sit outside it, and the output-only line is always enabled.

Top module: `gpio_grp_port`

## Requirements
- R1: Address 0 is the data register and address 1 is the direction register. In the data register, lines 0-4 sit at bits 14:10, lines 5-7 at bits 17:15, lines 8-9 at bits 21:20, the input-only lines 10-11 at bits 19:18 and the output-only line 12 at bit 22. Line n is `pad_o[n]` and, for n < 12, `pad_i[n]`.
- R2: Direction bit 0 controls group 0 (lines 0-4), bit 1 controls group 1 (lines 5-7) and bit 2 controls group 2 (lines 8-9). A 1 makes the whole group drive and a 0 makes it an input. `grp_oe_o` follows the direction register one cycle after the write.
- R3: While reset is asserted and after it is released, `grp_oe_o` is 0, `pad_o` is 0, and both registers read 0 when the input lines are low.
- R4: A write to the data register updates the drive value of every bidirectional line on the next cycle, whatever the direction of its group.
- R5: The input-only lines ignore writes: their `pad_o` bits stay 0 and their read bits show the pin.
- R6: The output-only line always drives `pad_o[12]` from data bit 22 and reads that value back.
- R7: Each input passes through two flops. A pin change shows in the readback after two rising edges and not after one.
- R8: A bidirectional line in an output group reads back its register value. A line in an input group reads back its synchronized pin.
- R9: Unmapped bits of both registers read 0, unmapped addresses read 0, and writes to unmapped addresses change nothing.
- R10: Without a write strobe, `pad_o` and `grp_oe_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| pad_i | input | 12 | Pin levels of lines 0-11 |
| pad_o | output | 13 | Drive values of lines 0-12 |
| grp_oe_o | output | 3 | Tri-state enable per bidirectional group |

## Verification
The first pattern writes all ones with every group set as input. It separates lines that store a drive value from the input-only lines, which must ignore the write, and it confirms that readback shows pins rather than registers. Mixed direction words such as 101 catch swapped group enables or groups mapped to the wrong bits. A pin step that is read after one edge and then after two edges tells a two-flop synchronizer from a one-flop or missing one. Random direction words, data words and pin patterns then exercise every mix of driving and sampling lines. Writes to unmapped addresses and long idle stretches show that nothing changes without a valid write.

// File: rtl/gpio_grp_pkg.sv
`timescale 1ns/1ps
package gpio_grp_pkg;
  localparam int NGRP   = 3;
  localparam int NPIN   = 13;
  localparam int NIN    = 2;
  localparam int IN_PIN = 10;
  localparam int IN_BIT = 18;
  localparam int OUT_PIN = 12;
  localparam int OUT_BIT = 22;
  localparam int NSYNC  = NPIN - 1;  // every line except the output-only one
  localparam int GRP_W   [NGRP] = '{5, 3, 2};
  localparam int GRP_PIN [NGRP] = '{0, 5, 8};
  localparam int GRP_BIT [NGRP] = '{10, 15, 20};

  function automatic int pin_bit(int p);
    for (int g = 0; g < NGRP; g++)
      if (p >= GRP_PIN[g] && p < GRP_PIN[g] + GRP_W[g]) return GRP_BIT[g] + p - GRP_PIN[g];
    if (p >= IN_PIN && p < IN_PIN + NIN) return IN_BIT + p - IN_PIN;
    return OUT_BIT;
  endfunction

  function automatic logic [31:0] data_mask();
    logic [31:0] m = '0;
    for (int p = 0; p < NPIN; p++) m[pin_bit(p)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_grp_sync.sv
`timescale 1ns/1ps
module gpio_grp_sync #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_grp_regs.sv
`timescale 1ns/1ps
module gpio_grp_regs
  import gpio_grp_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int A_DATA = 0,
  parameter int A_DIR  = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  output logic [NPIN-1:0] drv_o,
  output logic [NGRP-1:0] dir_o
);
  logic wr_data, wr_dir;
  logic unused_wdata;

  assign wr_data = we_i && (addr_i == AW'(A_DATA));
  assign wr_dir  = we_i && (addr_i == AW'(A_DIR));
  assign unused_wdata = ^wdata_i;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (p >= IN_PIN && p < IN_PIN + NIN) begin : g_in_only
      assign drv_o[p] = 1'b0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      drv_o[p] <= 1'b0;
        else if (wr_data) drv_o[p] <= wdata_i[pin_bit(p)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= '0;
    else if (wr_dir) dir_o <= wdata_i[NGRP-1:0];
  end
endmodule

// File: rtl/gpio_grp_rdmux.sv
`timescale 1ns/1ps
module gpio_grp_rdmux
  import gpio_grp_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int A_DATA = 0,
  parameter int A_DIR  = 1
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NPIN-1:0]  drv_i,
  input  logic [NGRP-1:0]  dir_i,
  input  logic [NSYNC-1:0] sync_i,
  output logic [DW-1:0]    rdata_o
);
  logic unused_drv;
  assign unused_drv = ^drv_i[IN_PIN +: NIN];

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_DATA)) begin
      for (int g = 0; g < NGRP; g++)
        for (int i = 0; i < GRP_W[g]; i++)
          rdata_o[GRP_BIT[g] + i] = dir_i[g] ? drv_i[GRP_PIN[g] + i] : sync_i[GRP_PIN[g] + i];
      for (int i = 0; i < NIN; i++)
        rdata_o[IN_BIT + i] = sync_i[IN_PIN + i];
      rdata_o[OUT_BIT] = drv_i[OUT_PIN];
    end else if (addr_i == AW'(A_DIR)) begin
      rdata_o[NGRP-1:0] = dir_i;
    end
  end
endmodule

// File: rtl/gpio_grp_port.sv
`timescale 1ns/1ps
module gpio_grp_port
  import gpio_grp_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int A_DATA = 0,
  parameter int A_DIR  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             we_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NSYNC-1:0] pad_i,
  output logic [NPIN-1:0]  pad_o,
  output logic [NGRP-1:0]  grp_oe_o
);
  logic [NPIN-1:0]  drv;
  logic [NGRP-1:0]  dir;
  logic [NSYNC-1:0] pin_sync;

  gpio_grp_regs #(.AW(AW), .DW(DW), .A_DATA(A_DATA), .A_DIR(A_DIR)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .drv_o(drv), .dir_o(dir)
  );

  gpio_grp_sync #(.W(NSYNC)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pin_sync)
  );

  gpio_grp_rdmux #(.AW(AW), .DW(DW), .A_DATA(A_DATA), .A_DIR(A_DIR)) u_rdmux (
    .addr_i, .drv_i(drv), .dir_i(dir), .sync_i(pin_sync), .rdata_o
  );

  assign pad_o    = drv;
  assign grp_oe_o = dir;
endmodule

// File: rtl/gpio_grp_port_chk.sv
`timescale 1ns/1ps
module gpio_grp_port_chk
  import gpio_grp_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int A_DATA = 0,
  parameter int A_DIR  = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             we_i,
  input logic [DW-1:0]    rdata_o,
  input logic [NSYNC-1:0] pad_i,
  input logic [NPIN-1:0]  pad_o,
  input logic [NGRP-1:0]  grp_oe_o
);
  localparam logic [31:0] MASK = data_mask();
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_reset_R3: assert property (@(posedge clk_i)
    !rst_ni |-> (grp_oe_o == '0 && pad_o == '0));

  assert_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(A_DIR)) |=> grp_oe_o == $past(wdata_i[NGRP-1:0]));

  assert_out_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(A_DATA)) |=> pad_o[OUT_PIN] == $past(wdata_i[OUT_BIT]));

  assert_in_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_o[IN_PIN +: NIN] == '0);

  assert_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && addr_i == AW'(A_DATA)) |-> rdata_o[IN_BIT +: NIN] == $past(pad_i[IN_PIN +: NIN], 2));

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_o) && $stable(grp_oe_o)));

  assert_unmapped_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != AW'(A_DATA) && addr_i != AW'(A_DIR)) |-> rdata_o == '0);

  assert_unmapped_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_DATA)) |-> (rdata_o & ~DW'(MASK)) == '0);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assert_drive_readback_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == AW'(A_DATA) && grp_oe_o[g]) |->
        rdata_o[GRP_BIT[g] +: GRP_W[g]] == pad_o[GRP_PIN[g] +: GRP_W[g]]);
  end
endmodule

bind gpio_grp_port gpio_grp_port_chk #(.AW(AW), .DW(DW), .A_DATA(A_DATA), .A_DIR(A_DIR)) u_chk (.*);

// File: tb/gpio_grp_port_bench.sv
`timescale 1ns/1ps
module gpio_grp_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [11:0] pad_i = '0;
  logic [12:0] pad_o;
  logic [2:0]  grp_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0]  m_dir = '0;
  logic [12:0] m_drv = '0;

  always #2.5 clk_i = ~clk_i;

  gpio_grp_port u_gpio_grp_port (.*);

  // R1 bit position of line p in the data register
  function automatic int bpos(int p);
    if (p < 5)  return 10 + p;
    if (p < 8)  return 15 + p - 5;
    if (p < 10) return 20 + p - 8;
    if (p < 12) return 18 + p - 10;
    return 22;
  endfunction

  function automatic int grp_of(int p);
    return (p < 5) ? 0 : (p < 8) ? 1 : 2;
  endfunction

  function automatic logic [31:0] exp_data(logic [2:0] d, logic [12:0] v, logic [11:0] pins);
    logic [31:0] r = '0;
    for (int p = 0; p < 13; p++) begin
      if (p == 12)      r[bpos(p)] = v[12];
      else if (p >= 10) r[bpos(p)] = pins[p];
      else              r[bpos(p)] = d[grp_of(p)] ? v[p] : pins[p];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 4'd0)
      for (int p = 0; p < 13; p++) if (p < 10 || p == 12) m_drv[p] = d[bpos(p)];
    if (a == 4'd1) m_dir = d[2:0];
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    check({req, " pad_o"}, 32'(pad_o), 32'(m_drv));
    check({req, " grp_oe"}, 32'(grp_oe_o), 32'(m_dir));
    rd(4'd0, v);
    check({req, " data"}, v, exp_data(m_dir, m_drv, pad_i));
    rd(4'd1, v);
    check({req, " dir"}, v, 32'(m_dir));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk_i);
    // R3 during reset
    check("R3 reset pad_o", 32'(pad_o), 32'h0);
    check("R3 reset grp_oe", 32'(grp_oe_o), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_all("R3 after reset");

    // R4 R5 R6: all ones with every group as input
    wr(4'd0, 32'hFFFF_FFFF);
    check("R4 R5 R6 pad_o", 32'(pad_o), 32'h13FF);
    rd(4'd0, v);
    check("R5 R6 R8 readback", v, 32'h0040_0000);

    // R2 R8 mixed directions
    wr(4'd1, 32'h5);
    check("R2 grp_oe 101", 32'(grp_oe_o), 32'h5);
    rd(4'd0, v);
    check("R8 mixed readback", v, 32'h0070_7C00);
    wr(4'd1, 32'h2);
    check_all("R2 R8 dir 010");

    // R9 unmapped addresses and bits
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd7, 32'h0);
    check_all("R9 no effect");
    rd(4'd2, v);  check("R9 addr 2", v, 32'h0);
    rd(4'd15, v); check("R9 addr 15", v, 32'h0);
    wr(4'd1, 32'hFFFF_FFF8);
    rd(4'd1, v);  check("R9 dir upper bits", v, 32'h0);

    // R7 two-flop latency
    @(negedge clk_i); pad_i = 12'hFFF;
    @(negedge clk_i); addr_i = 4'd0; #1;
    check("R7 after one edge", rdata_o, exp_data(3'b000, m_drv, 12'h000));
    @(negedge clk_i); #1;
    check("R7 after two edges", rdata_o, exp_data(3'b000, m_drv, 12'hFFF));
    check("R5 input-only pins read", rdata_o & 32'h000C_0000, 32'h000C_0000);

    // R10 idle with toggling address and data
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      addr_i = 4'($urandom); wdata_i = $urandom;
    end
    check_all("R10 idle");

    // random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 4)
        0: wr(4'd1, $urandom);
        1: wr(4'd0, $urandom);
        2: wr(4'($urandom), $urandom);
        default: begin
          @(negedge clk_i); pad_i = 12'($urandom);
          repeat (2) @(negedge clk_i);
        end
      endcase
      check_all("R1 R2 R4 R8 random");
    end

    // R1 line mapping walk
    wr(4'd1, 32'h7);
    for (int p = 0; p < 13; p++) begin
      wr(4'd0, 32'h1 << bpos(p));
      check("R1 walk pad_o", 32'(pad_o), (p == 10 || p == 11) ? 32'h0 : (32'h1 << p));
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule